// File: doc/BRIEF.md
# Receive Drop Statistics Register

This block keeps two counts of received frames that were thrown away, and presents both in one 32-bit read-only status word. One count records frames lost because the host had no free receive descriptor ready. The other records frames lost because the receive FIFO overran. Each count has a sticky flag of its own that records that the count wrapped past its maximum. The frame reception logic supplies each drop as a one-cycle pulse.

Software polls the word through a read strobe. In the cycle of the strobe, the word shows the counts and flags as they stand. On the next clock edge, both counts and both flags return to zero. A drop pulse that arrives in the same cycle as the strobe is counted into the freshly cleared counter, so no event is lost. There is no write path. The word changes only through drop pulses and reads.

Top module: `rxdrop_stats`

## Requirements
- R1: Bits 15:0 of `stat_word` hold the no-descriptor drop count. The count rises by exactly one on each clock edge where `nodesc_drop` is high and `rd_strobe` is low.
- R2: Bits 27:17 of `stat_word` hold the FIFO-overrun drop count. The count rises by exactly one on each clock edge where `fifo_drop` is high and `rd_strobe` is low.
- R3: A `nodesc_drop` pulse taken while bits 15:0 are 0xFFFF wraps them to 0 and sets bit 16. Bit 16 then stays set until a read.
- R4: A `fifo_drop` pulse taken while bits 27:17 are 0x7FF wraps them to 0 and sets bit 28. Bit 28 then stays set until a read.
- R5: In the cycle `rd_strobe` is high, `stat_word` shows the pre-read values. After that edge, both counts and both flags read as zero, unless R6 applies.
- R6: A drop pulse in the same cycle as `rd_strobe` leaves its count at 1 after the edge, with its flag clear.
- R7: Bits 31:29 of `stat_word` always read as zero.
- R8: A synchronous active-high reset makes the whole word zero.
- R9: On an edge with no pulse and no read, every field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nodesc_drop | input | 1 | One-cycle pulse: a frame was dropped because no receive descriptor was free |
| fifo_drop | input | 1 | One-cycle pulse: a frame was dropped because the receive FIFO overran |
| rd_strobe | input | 1 | Read of the status word; clears counts and flags at the edge |
| stat_word | output | 32 | Packed counts, sticky wrap flags and zero bits |

## Verification
The properties assume that each input is a clean level sampled once per clock. They make no assumption about pulse spacing, because the counters accept a pulse on every cycle. Back-to-back drop pulses and pulses that coincide with a read are therefore legal, and the random stimulus produces both freely. The random phase mixes reads at a low rate with dense pulses. Directed runs drive each counter through a long burst with no read, so that it reaches its all-ones value and wraps.

// File: rtl/rxdrop_pkg.sv
package rxdrop_pkg;
    localparam int WORD_W   = 32;
    localparam int NODESC_W = 16;
    localparam int FIFO_W   = 11;
    localparam int PAD_W    = WORD_W - NODESC_W - FIFO_W - 2;

    typedef struct packed {
        logic [PAD_W-1:0]    pad;
        logic                fifo_wrap;
        logic [FIFO_W-1:0]   fifo_cnt;
        logic                nodesc_wrap;
        logic [NODESC_W-1:0] nodesc_cnt;
    } stat_word_t;

    function automatic stat_word_t pack_word(
        input logic [NODESC_W-1:0] nc, input logic nf,
        input logic [FIFO_W-1:0]   fc, input logic ff);
        stat_word_t w;
        w.pad         = '0;
        w.fifo_wrap   = ff;
        w.fifo_cnt    = fc;
        w.nodesc_wrap = nf;
        w.nodesc_cnt  = nc;
        return w;
    endfunction
endpackage

// File: rtl/drop_counter.sv
module drop_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] base_cnt;
    logic         base_wrap;

    // A clear takes effect first, so a coincident event lands on zero.
    always_comb begin
        base_cnt  = clr ? '0 : cnt;
        base_wrap = clr ? 1'b0 : wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wrap <= 1'b0;
        end else if (inc) begin
            cnt  <= base_cnt + 1'b1;
            wrap <= base_wrap | (&base_cnt);
        end else begin
            cnt  <= base_cnt;
            wrap <= base_wrap;
        end
    end
endmodule

// File: rtl/rxdrop_stats.sv
module rxdrop_stats
    import rxdrop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nodesc_drop,
    input  logic              fifo_drop,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] stat_word
);
    logic [NODESC_W-1:0] nodesc_cnt;
    logic                nodesc_wrap;
    logic [FIFO_W-1:0]   fifo_cnt;
    logic                fifo_wrap;
    stat_word_t          word_s;

    drop_counter #(.W(NODESC_W)) u_nodesc (
        .clk(clk), .rst(rst), .clr(rd_strobe), .inc(nodesc_drop),
        .cnt(nodesc_cnt), .wrap(nodesc_wrap)
    );

    drop_counter #(.W(FIFO_W)) u_fifo (
        .clk(clk), .rst(rst), .clr(rd_strobe), .inc(fifo_drop),
        .cnt(fifo_cnt), .wrap(fifo_wrap)
    );

    always_comb begin
        word_s    = pack_word(nodesc_cnt, nodesc_wrap, fifo_cnt, fifo_wrap);
        stat_word = word_s;
    end
endmodule

// File: rtl/rxdrop_stats_chk.sv
module rxdrop_stats_chk
    import rxdrop_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              nodesc_drop,
    input logic              fifo_drop,
    input logic              rd_strobe,
    input logic [WORD_W-1:0] stat_word
);
    stat_word_t w;
    assign w = stat_word;

    p_nodesc_incr_r1: assert property (@(posedge clk) disable iff (rst)
        (!rd_strobe && nodesc_drop && !(&w.nodesc_cnt)) |=>
        (w.nodesc_cnt == $past(w.nodesc_cnt) + 1'b1));

    p_fifo_incr_r2: assert property (@(posedge clk) disable iff (rst)
        (!rd_strobe && fifo_drop && !(&w.fifo_cnt)) |=>
        (w.fifo_cnt == $past(w.fifo_cnt) + 1'b1));

    p_nodesc_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (!rd_strobe && nodesc_drop && (&w.nodesc_cnt)) |=>
        (w.nodesc_cnt == '0 && w.nodesc_wrap));

    p_nodesc_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (!rd_strobe && w.nodesc_wrap) |=> w.nodesc_wrap);

    p_fifo_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (!rd_strobe && fifo_drop && (&w.fifo_cnt)) |=>
        (w.fifo_cnt == '0 && w.fifo_wrap));

    p_fifo_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (!rd_strobe && w.fifo_wrap) |=> w.fifo_wrap);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !nodesc_drop && !fifo_drop) |=> (stat_word == '0));

    p_read_keeps_event_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && nodesc_drop) |=> (w.nodesc_cnt == 1 && !w.nodesc_wrap));

    p_read_keeps_fifo_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && fifo_drop) |=> (w.fifo_cnt == 1 && !w.fifo_wrap));

    p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
        w.pad == '0);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!rd_strobe && !nodesc_drop && !fifo_drop) |=> $stable(stat_word));
endmodule

bind rxdrop_stats rxdrop_stats_chk u_chk (
    .clk(clk), .rst(rst), .nodesc_drop(nodesc_drop), .fifo_drop(fifo_drop),
    .rd_strobe(rd_strobe), .stat_word(stat_word)
);

// File: tb/test_rxdrop_stats.sv
module test_rxdrop_stats;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nd = 1'b0, fd = 1'b0, rd = 1'b0;
    logic [31:0] word;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    // Bench model
    int unsigned m_nc = 0, m_fc = 0;
    bit          m_nf = 0, m_ff = 0;

    always #4 clk = ~clk;

    rxdrop_stats i_rxdrop_stats (
        .clk(clk), .rst(rst), .nodesc_drop(nd), .fifo_drop(fd),
        .rd_strobe(rd), .stat_word(word)
    );

    function automatic logic [31:0] model_word();
        return {3'b000, m_ff, m_fc[10:0], m_nf, m_nc[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge(input bit n, input bit f, input bit r);
        if (r) begin m_nc = 0; m_fc = 0; m_nf = 0; m_ff = 0; end
        if (n) begin
            if (m_nc == 16'hFFFF) begin m_nf = 1; m_nc = 0; end else m_nc++;
        end
        if (f) begin
            if (m_fc == 11'h7FF) begin m_ff = 1; m_fc = 0; end else m_fc++;
        end
    endtask

    // Drive one cycle, then check every field with the tag it exercises.
    task automatic step(input bit n, input bit f, input bit r);
        logic [31:0] pre;
        nd = n; fd = f; rd = r;
        if (r) chk("R5 pre-read value", word, model_word());
        pre = model_word();
        @(posedge clk);
        model_edge(n, f, r);
        @(negedge clk);
        nd = 0; fd = 0; rd = 0;
        if (r && (n || f))      chk("R6 coincident event", word, model_word());
        else if (r)             chk("R5 cleared after read", word, model_word());
        else if (!n && !f)      chk("R9 idle hold", word, pre);
        else if (n && pre[15:0] == 16'hFFFF) chk("R3 no-desc wrap", word, model_word());
        else if (f && pre[27:17] == 11'h7FF) chk("R4 fifo wrap", word, model_word());
        else begin
            chk("R1 no-desc count", {16'h0, word[15:0]}, {16'h0, m_nc[15:0]});
            chk("R2 fifo count", {21'h0, word[27:17]}, {21'h0, m_fc[10:0]});
            chk("R3 R4 flags", {30'h0, word[28], word[16]}, {30'h0, m_ff, m_nf});
        end
        chk("R7 zero bits", {29'h0, word[31:29]}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8 reset state", word, 32'h0);
        // Directed: basic counting, read, coincident read plus pulses
        step(1, 0, 0); step(0, 1, 0); step(1, 1, 0); step(0, 0, 0);
        step(0, 0, 1);
        step(1, 1, 0); step(1, 1, 1);
        step(0, 0, 1);
        // Directed: drive the no-descriptor count to all ones and wrap it
        for (int i = 0; i < 65535; i++) step(1, 0, 0);
        chk("R3 all ones reached", {16'h0, word[15:0]}, 32'h0000FFFF);
        step(1, 0, 0);
        chk("R3 flag set", {31'h0, word[16]}, 32'h1);
        step(1, 0, 0); step(0, 0, 0);
        chk("R3 flag sticky", {31'h0, word[16]}, 32'h1);
        step(0, 0, 1);
        // Directed: wrap the FIFO count
        for (int i = 0; i < 2048; i++) step(0, 1, 0);
        chk("R4 flag set", {31'h0, word[28]}, 32'h1);
        step(0, 1, 0);
        chk("R4 flag sticky", {31'h0, word[28]}, 32'h1);
        step(1, 1, 1);
        chk("R6 flags cleared", {30'h0, word[28], word[16]}, 32'h0);
        // Random mix
        for (int i = 0; i < 6000; i++)
            step($urandom_range(1, 0) == 1, $urandom_range(2, 0) == 0,
                 $urandom_range(63, 0) == 0);
        // Mid-run reset
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        m_nc = 0; m_fc = 0; m_nf = 0; m_ff = 0;
        chk("R8 reset mid-run", word, 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule